// File: doc/BRIEF.md
# Kickable Watchdog Timer

This block is a watchdog timer controlled through a small 32-bit register bus with address, write strobe, write data, read strobe and read data. A prescaler turns the core clock into count ticks, and a 16-bit down-counter counts those ticks from a value that software loads. When the count runs out while the timer is enabled, the block sends a reset request of fixed length to the chip's reset network. It then reloads the counter and keeps counting.

Software keeps the system alive by writing a restart ("kick") bit in the status register often enough. A sticky flag records that the last reset came from this timer. The flag is cleared only by power-on reset or by an explicit software clear, so firmware can read it after the system reset that the timer itself caused. There are two reset inputs. `por_n` resets everything. `sys_rst_n` resets everything except the cause flag.

Top module: `wdog_timer`

Register map (byte offsets; any other offset reads zero and ignores writes):
- 0x00 status/command: bit 1 is the cause flag (reads the flag, write 1 to clear); bit 9 is the kick command (write 1, always reads 0).
- 0x20 control: bit 7 is enable; bits 31:16 are the prescale value.
- 0x24 load: bits 15:0 hold the reload value; upper bits read 0.

## Requirements
- R1: After reset, control reads 0, load reads 0x0000FFFF, status reads 0 and `wdog_rst_req` is low.
- R2: Control at 0x20 reads back the enable (bit 7) and prescale (bits 31:16) that were written; load at 0x24 reads back its low 16 bits with bits 31:16 as zero.
- R3: A prescale value P gives one count tick every P clocks; P of 0 or 1 gives a tick every clock.
- R4: With load L and prescale P, `wdog_rst_req` rises (L+1)*max(P,1) clocks after the clock edge on which a kick or an enable write lands.
- R5: Each expiry holds `wdog_rst_req` high for exactly PULSE_CLKS (default 4) clocks and reloads the counter from the load register, so the next expiry follows (L+1)*max(P,1) clocks later if nobody kicks.
- R6: Writing 1 to bit 9 at 0x00 reloads the counter from the load register and clears the prescaler, so kicks more frequent than the expiry period keep `wdog_rst_req` low.
- R7: A write to the load register does not change the running count; it is used only at the next kick or reload.
- R8: While enable is 0, the counter and prescaler hold their values; re-enabling resumes the countdown from where it stopped.
- R9: A kick while enable is 0 reloads the counter and never raises `wdog_rst_req`.
- R10: Every expiry sets the cause flag (bit 1 at 0x00). `sys_rst_n` leaves the flag set while it clears control and load; `por_n` clears the flag.
- R11: Writing 1 to bit 1 at 0x00 clears the cause flag; writing 0 there leaves it unchanged.
- R12: Bit 9 at 0x00 always reads 0; reads of unmapped offsets return 0, and writes to them change no register.
- R13: A load of 0xFFFF with prescale 0 expires after 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, clears every register including the cause flag |
| sys_rst_n | input | 1 | System reset, active low, clears all state except the cause flag |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe; data returns in the same cycle |
| bus_rdata | output | 32 | Read data, zero when the read strobe is low |
| wdog_rst_req | output | 1 | Reset request pulse to the reset network |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 16-bit prescale field and a 4-clock request pulse. Because the load and prescale values come through registers, small values such as a load of 2 with a prescale of 3 bring expiry, auto-reload and back-to-back pulses within a few dozen clocks. The same defaults also allow the full 0xFFFF load, which reaches the 65536-clock boundary. The checks cover enable/disable around a running count and the survival of the cause flag across the system reset.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned OFF_STAT  = 'h00;
  localparam int unsigned OFF_CTRL  = 'h20;
  localparam int unsigned OFF_LOAD  = 'h24;
  localparam int unsigned BIT_CAUSE = 1;
  localparam int unsigned BIT_KICK  = 9;
  localparam int unsigned BIT_EN    = 7;
  localparam int unsigned PRE_LSB   = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_CTRL,
    SEL_LOAD
  } reg_sel_e;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              ren,
  input  logic              expire,
  output logic [BUS_W-1:0]  rdata,
  output logic              en,
  output logic [PRE_W-1:0]  presc,
  output logic [CNT_W-1:0]  load,
  output logic              kick,
  output logic              cause
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);

  reg_sel_e sel;
  logic     wr_stat, wr_ctrl, wr_load;

  always_comb begin
    case (addr)
      A_STAT:  sel = SEL_STAT;
      A_CTRL:  sel = SEL_CTRL;
      A_LOAD:  sel = SEL_LOAD;
      default: sel = SEL_NONE;
    endcase
  end

  assign wr_stat = wen && (sel == SEL_STAT);
  assign wr_ctrl = wen && (sel == SEL_CTRL);
  assign wr_load = wen && (sel == SEL_LOAD);
  assign kick    = wr_stat && wdata[BIT_KICK];

  // control and load: cleared by either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      presc <= '0;
      load  <= '1;
    end else begin
      if (wr_ctrl) begin
        en    <= wdata[BIT_EN];
        presc <= wdata[PRE_LSB +: PRE_W];
      end
      if (wr_load) begin
        load <= wdata[CNT_W-1:0];
      end
    end
  end

  // cause flag lives on the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause <= 1'b0;
    end else if (expire) begin
      cause <= 1'b1;
    end else if (wr_stat && wdata[BIT_CAUSE]) begin
      cause <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (ren) begin
      case (sel)
        SEL_STAT: rdata[BIT_CAUSE] = cause;
        SEL_CTRL: begin
          rdata[BIT_EN]            = en;
          rdata[PRE_LSB +: PRE_W]  = presc;
        end
        SEL_LOAD: rdata[CNT_W-1:0] = load;
        default:  rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic             wrap;

  // >= keeps a shrunk prescale from running the divider past its end
  assign wrap = (presc <= PRE_W'(1)) || (pcnt >= presc - PRE_W'(1));
  assign tick = en && !restart && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
    end else if (en) begin
      pcnt <= wrap ? '0 : pcnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdog_down.sv
`timescale 1ns/1ps
module wdog_down #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PULSE_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             rst_req
);
  localparam int unsigned PW = $clog2(PULSE_CLKS + 1);

  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
    end else if (restart) begin
      cnt <= load;
    end else if (tick) begin
      cnt <= (cnt == '0) ? load : cnt - CNT_W'(1);
    end
  end

  generate
    if (PULSE_CLKS <= 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire;
      end
    end else begin : g_stretch
      logic [PW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          left <= '0;
        end else if (expire) begin
          left <= PW'(PULSE_CLKS);
        end else if (left != '0) begin
          left <= left - PW'(1);
        end
      end
      assign rst_req = (left != '0);
    end
  endgenerate
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_W      = 16,
  parameter int unsigned PULSE_CLKS = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_ren,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wdog_rst_req
);
  logic             rst_n;
  logic             en, kick, cause, tick, expire;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] load, cnt;

  assign rst_n = por_n & sys_rst_n;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata), .ren(bus_ren),
    .expire(expire), .rdata(bus_rdata),
    .en(en), .presc(presc), .load(load), .kick(kick), .cause(cause)
  );

  wdog_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(kick),
    .presc(presc), .tick(tick)
  );

  wdog_down #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) down_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(kick),
    .load(load), .cnt(cnt), .expire(expire), .rst_req(wdog_rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [31:0]       bus_wdata,
  input logic              bus_ren,
  input logic [31:0]       bus_rdata,
  input logic              wdog_rst_req,
  input logic              en,
  input logic              kick,
  input logic              cause,
  input logic [CNT_W-1:0]  load,
  input logic [CNT_W-1:0]  cnt
);
  logic live;
  assign live = por_n && sys_rst_n;

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!live)
    (!en && !kick) |=> $stable(cnt));

  assert_kick_reloads_R6: assert property (@(posedge clk) disable iff (!live)
    kick |=> (cnt == $past(load)));

  assert_no_req_when_off_R9: assert property (@(posedge clk) disable iff (!live)
    $rose(wdog_rst_req) |-> $past(en));

  assert_cause_on_expiry_R10: assert property (@(posedge clk) disable iff (!live)
    $rose(wdog_rst_req) |-> cause);

  assert_cause_clear_w1c_R11: assert property (@(posedge clk) disable iff (!live)
    $fell(cause) |-> $past(bus_wen && bus_addr == ADDR_W'('h00) && bus_wdata[1]));

  assert_kick_bit_reads_zero_R12: assert property (@(posedge clk) disable iff (!live)
    (bus_ren && bus_addr == ADDR_W'('h00)) |-> !bus_rdata[9]);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!live)
    (bus_ren && bus_addr != ADDR_W'('h00) && bus_addr != ADDR_W'('h20)
     && bus_addr != ADDR_W'('h24)) |-> (bus_rdata == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
  .bus_ren(bus_ren), .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req),
  .en(en), .kick(kick), .cause(cause), .load(load), .cnt(cnt)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_LOAD = 8'h24;
  localparam logic [31:0] KICK  = 32'h0000_0200;
  localparam logic [31:0] CLR   = 32'h0000_0002;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic        ren = 1'b0;
  logic [31:0] rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_timer dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata), .bus_ren(ren),
    .bus_rdata(rdata), .wdog_rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; ren = 1'b1;
    #1;
    d = rdata;
    ren = 1'b0;
  endtask

  task automatic wait_rise(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (rst_req) break;
    end
  endtask

  function automatic logic [31:0] ctrl_val(input int p, input bit e);
    return (32'(p) << 16) | (e ? 32'h80 : 32'h0);
  endfunction

  task automatic quiesce();
    bus_wr(A_CTRL, 32'h0);
    repeat (PULSE + 2) @(negedge clk);
    bus_wr(A_STAT, CLR);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_CTRL, d); chk(d == 32'h0, "R1 ctrl", d, 32'h0);
    bus_rd(A_LOAD, d); chk(d == 32'hFFFF, "R1 load", d, 32'hFFFF);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R1 status", d, 32'h0);
    chk(rst_req == 1'b0, "R1 req", 32'(rst_req), 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'hA5C3_0000);
    bus_rd(A_CTRL, d); chk(d == 32'hA5C3_0000, "R2 ctrl prescale", d, 32'hA5C3_0000);
    bus_wr(A_LOAD, 32'hDEAD_1234);
    bus_rd(A_LOAD, d); chk(d == 32'h0000_1234, "R2 load low half", d, 32'h1234);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_timing(input int p, input int l, input string req);
    int n, exp;
    exp = (l + 1) * ((p < 1) ? 1 : p);
    quiesce();
    bus_wr(A_LOAD, 32'(l));
    bus_wr(A_STAT, KICK);
    bus_wr(A_CTRL, ctrl_val(p, 1'b1));
    wait_rise(exp + 20, n);
    chk(rst_req && n == exp, req, 32'(n), 32'(exp));
  endtask

  task automatic t_pulse_reload();
    int n, h;
    t_timing(3, 2, "R4 R3 P=3 L=2");
    h = 1;
    forever begin
      @(negedge clk);
      if (rst_req) h++; else break;
    end
    chk(h == PULSE, "R5 pulse width", 32'(h), 32'(PULSE));
    wait_rise(20, n);
    chk(rst_req && (h + n) == 9, "R5 reload period", 32'(h + n), 32'd9);
  endtask

  task automatic t_kick_keeps();
    int n;
    bit seen = 1'b0;
    quiesce();
    bus_wr(A_LOAD, 32'd4);
    bus_wr(A_STAT, KICK);
    bus_wr(A_CTRL, ctrl_val(2, 1'b1));
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (rst_req) seen = 1'b1;
      end
      bus_wr(A_STAT, KICK);
    end
    chk(!seen, "R6 kicks hold off expiry", 32'(seen), 32'h0);
    wait_rise(40, n);
    chk(rst_req && n == 10, "R6 expiry after last kick", 32'(n), 32'd10);
  endtask

  task automatic t_load_deferred();
    int n;
    quiesce();
    bus_wr(A_LOAD, 32'd5);
    bus_wr(A_STAT, KICK);
    bus_wr(A_LOAD, 32'd1);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    wait_rise(30, n);
    chk(rst_req && n == 6, "R7 old count kept", 32'(n), 32'd6);
  endtask

  task automatic t_hold();
    int n;
    logic [31:0] d;
    bit seen = 1'b0;
    quiesce();
    bus_wr(A_LOAD, 32'd10);
    bus_wr(A_STAT, KICK);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    repeat (3) @(negedge clk);
    bus_wr(A_CTRL, ctrl_val(1, 1'b0));
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    chk(!seen, "R8 no expiry while off", 32'(seen), 32'h0);
    bus_rd(A_CTRL, d); chk(d[7] == 1'b0, "R8 enable reads 0", d, 32'h0001_0000);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    wait_rise(30, n);
    chk(rst_req && n == 7, "R8 resume from held count", 32'(n), 32'd7);
  endtask

  task automatic t_kick_disabled();
    int n;
    bit seen = 1'b0;
    quiesce();
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_STAT, KICK);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    bus_wr(A_STAT, KICK);
    chk(!seen, "R9 kick while off no request", 32'(seen), 32'h0);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    wait_rise(10, n);
    chk(rst_req && n == 1, "R9 reload took effect", 32'(n), 32'd1);
  endtask

  task automatic t_cause();
    logic [31:0] d;
    int n;
    quiesce();
    bus_rd(A_STAT, d); chk(d == 32'h0, "R11 cleared by write 1", d, 32'h0);
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_STAT, KICK);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    wait_rise(10, n);
    bus_rd(A_STAT, d); chk(d == CLR, "R10 set on expiry", d, CLR);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, d); chk(d == CLR, "R11 write 0 keeps flag", d, CLR);
    sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    bus_rd(A_STAT, d); chk(d == CLR, "R10 survives system reset", d, CLR);
    bus_rd(A_CTRL, d); chk(d == 32'h0, "R10 ctrl cleared by system reset", d, 32'h0);
    bus_rd(A_LOAD, d); chk(d == 32'hFFFF, "R10 load cleared by system reset", d, 32'hFFFF);
    chk(rst_req == 1'b0, "R10 request dropped", 32'(rst_req), 32'h0);
    bus_wr(A_STAT, CLR);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R11 write 1 clears", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    quiesce();
    bus_wr(A_CTRL, 32'h0003_0000);
    bus_wr(A_LOAD, 32'h0000_0077);
    bus_wr(8'h28, 32'hFFFF_FFFF);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h28, d); chk(d == 32'h0, "R12 unmapped 0x28 reads 0", d, 32'h0);
    bus_rd(8'h10, d); chk(d == 32'h0, "R12 unmapped 0x10 reads 0", d, 32'h0);
    bus_rd(A_CTRL, d); chk(d == 32'h0003_0000, "R12 ctrl untouched", d, 32'h0003_0000);
    bus_rd(A_LOAD, d); chk(d == 32'h77, "R12 load untouched", d, 32'h77);
    bus_wr(A_STAT, KICK);
    bus_rd(A_STAT, d); chk(d[9] == 1'b0, "R12 kick bit reads 0", d, 32'h0);
  endtask

  task automatic t_por();
    logic [31:0] d;
    int n;
    quiesce();
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_STAT, KICK);
    bus_wr(A_CTRL, ctrl_val(1, 1'b1));
    wait_rise(10, n);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R10 power-on reset clears flag", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_timing(0, 3, "R3 R4 P=0 L=3");
    t_timing(1, 3, "R3 R4 P=1 L=3");
    t_timing(5, 1, "R3 R4 P=5 L=1");
    t_pulse_reload();
    t_kick_keeps();
    t_load_deferred();
    t_hold();
    t_kick_disabled();
    t_cause();
    t_unmapped();
    t_timing(0, 65535, "R13 full load");
    t_por();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule